// File: doc/BRIEF.md
# Diagnostic Register Write-Unlock Guard

This block protects a diagnostic control register behind a key sequence. Software writes key values to a key register one write at a time. Only the low nibble of each write counts. Writes that arrive in the correct order carry the sequencer through six steps. After the last step the guard raises a write-enable flag. While that flag is set, software may request an adapter reset or hold the controller in reset through the diagnostic register. Without the flag, those two control bits ignore writes.

An adapter-reset request does three things: it emits a single-cycle reset request, it drops the write-enable flag, and it sets a sticky reset-history flag. Software clears the history flag by writing a one to it. A flush key (nibble 0x0) abandons any progress at once and also withdraws an unlock that has already been granted.

The block sits on a plain 32-bit register bus. Writes are single-cycle strobes. Read data is combinational from the address.

Top module: `diag_unlock_guard`

## Requirements
- R1: After synchronous reset, the diagnostic register (byte offset 0x08) reads 0x0000_0000, `hold_rst_o` is 0 and `rst_req_o` is 0.
- R2: Six separate writes to the key register (byte offset 0x04) with nibbles 0xF, 0x4, 0xB, 0x2, 0x7, 0xD in that order set bit 7 of the diagnostic register. Further key writes that are not 0x0 leave bit 7 set.
- R3: Only bits [3:0] of a key-register write are examined; bits [31:4] have no effect on progress.
- R4: A key write whose nibble is not the expected next key (and is not 0xF) returns progress to the start.
- R5: A mismatching key write whose nibble is 0xF leaves progress at step one, so the remaining five keys complete the unlock.
- R6: A key write of nibble 0x0 returns progress to the start and clears bit 7 if it was set.
- R7: While bit 7 is 0, writes to diagnostic bits 1 and 2 have no effect: `hold_rst_o` does not change and `rst_req_o` stays 0.
- R8: While bit 7 is 1, a diagnostic write loads bit 1 into the hold-reset level; it drives `hold_rst_o` and reads back in bit 1.
- R9: While bit 7 is 1, a diagnostic write with bit 2 set raises `rst_req_o` for exactly the one cycle after the write. It also clears bit 7 and sets bit 5. Bit 2 always reads as 0.
- R10: Writing 1 to diagnostic bit 5 clears the reset-history flag whether or not bit 7 is set; writing 0 leaves it unchanged.
- R11: The key register reads as 0x0000_0000.

Ports are listed in the order of the top module's port list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Single-cycle write strobe |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| rst_req_o | output | 1 | One-cycle adapter-reset request |
| hold_rst_o | output | 1 | Hold-in-reset level |

## Verification
The bench goes after the ordering corner cases first.

- **Wrong key equal to the first key.** A design that treated this like any other mismatch would demand a full restart, and the sequence would stay locked.
- **Wrong key partway through.** A design that merely stalled, instead of returning to the start, would unlock after the correct keys resume.
- **Flush after unlock.** A design that ignored the flush once unlocked would keep the enable bit set.

The bench also covers the reset request and the control gating.

- **Reset-request pulse.** It checks the pulse width and checks that the pulse also relocks the register. A level output, or a pulse that left the unlock in place, shows up in the cycle after.
- **Locked control writes.** Writes to the control bits while locked must change nothing.
- **Upper key bits.** Keys are sent with garbage in the upper bits. A decoder that compared the whole word would never unlock.

// File: rtl/diag_unlock_pkg.sv
// Shared constants for the diagnostic unlock guard: register offsets,
// bit positions inside the diagnostic register and the key sequence.
// Assumes byte addressing with 32-bit registers.
package diag_unlock_pkg;
    localparam int KEY_W      = 4;
    localparam int SEQ_LEN    = 6;
    localparam logic [7:0] KEY_OFS  = 8'h04;
    localparam logic [7:0] DIAG_OFS = 8'h08;
    localparam int BIT_WREN   = 7;
    localparam int BIT_HIST   = 5;
    localparam int BIT_ARST   = 2;
    localparam int BIT_HOLD   = 1;
    localparam logic [KEY_W-1:0] FLUSH_KEY = 4'h0;

    // Key expected at a given step of the unlock sequence.
    function automatic logic [KEY_W-1:0] seq_key(input int idx);
        case (idx)
            0:       seq_key = 4'hF;
            1:       seq_key = 4'h4;
            2:       seq_key = 4'hB;
            3:       seq_key = 4'h2;
            4:       seq_key = 4'h7;
            default: seq_key = 4'hD;
        endcase
    endfunction
endpackage

// File: rtl/key_tracker.sv
// Tracks progress through the ordered key sequence.
// Assumes key_wr is a single-cycle strobe carrying the key nibble.
// Step SEQ_LEN means unlocked; a flush key or force_lock returns to step 0.
module key_tracker
    import diag_unlock_pkg::*;
#(
    parameter int N_KEYS = SEQ_LEN,
    parameter int KW     = KEY_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          key_wr,
    input  logic [KW-1:0] key_val,
    input  logic          force_lock,
    output logic          unlocked
);
    localparam int STEP_W = $clog2(N_KEYS + 1);
    localparam logic [STEP_W-1:0] LAST = STEP_W'(N_KEYS);

    logic [STEP_W-1:0] step_q;
    logic [N_KEYS:0]   match;

    // One comparator per sequence position; the extra top slot never matches.
    for (genvar g = 0; g < N_KEYS; g++) begin : g_cmp
        assign match[g] = (key_val == seq_key(g));
    end
    assign match[N_KEYS] = 1'b0;

    assign unlocked = (step_q == LAST);

    // Advance on an expected key, restart on a mismatch, hold once unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= '0;
        end else if (force_lock) begin
            step_q <= '0;
        end else if (key_wr) begin
            if (key_val == FLUSH_KEY)
                step_q <= '0;
            else if (unlocked)
                step_q <= step_q;
            else if (match[step_q])
                step_q <= step_q + 1'b1;
            else if (match[0])
                step_q <= STEP_W'(1);
            else
                step_q <= '0;
        end
    end

    p_step_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        step_q <= LAST);
    p_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && key_val == FLUSH_KEY) |=> !unlocked);
    p_mismatch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && !force_lock && !unlocked && !match[step_q] && !match[0])
            |=> (step_q == '0));
endmodule

// File: rtl/diag_ctrl.sv
// Holds the diagnostic control state: hold-reset level, reset-history flag
// and the one-cycle reset request. Control writes are honoured only while
// unlocked. Assumes diag_wr is a single-cycle write strobe.
module diag_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic diag_wr,
    input  logic wr_hold,
    input  logic wr_arst,
    input  logic wr_hist,
    input  logic unlocked,
    output logic force_lock,
    output logic hold_q,
    output logic hist_q,
    output logic req_q
);
    logic take_arst;
    assign take_arst  = diag_wr && unlocked && wr_arst;
    assign force_lock = take_arst;

    // Hold-reset level, writable only while unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n)                  hold_q <= 1'b0;
        else if (diag_wr && unlocked) hold_q <= wr_hold;
    end

    // Sticky history: a reset request sets it, writing one clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)                   hist_q <= 1'b0;
        else if (take_arst)           hist_q <= 1'b1;
        else if (diag_wr && wr_hist)  hist_q <= 1'b0;
    end

    // Single-cycle reset request registered from the accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= take_arst;
    end

    p_pulse_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_q |=> !req_q);
    p_req_sets_hist_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_q |-> hist_q);
    p_req_relocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_q |-> !unlocked);
    p_hold_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(hold_q) |-> $past(unlocked));
    p_req_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_q) |-> $past(unlocked));
endmodule

// File: rtl/diag_unlock_guard.sv
// Top of the diagnostic write-unlock guard: decodes bus writes to the key
// and diagnostic registers and returns combinational read data.
// Assumes a single-cycle write strobe and byte addresses.
module diag_unlock_guard
    import diag_unlock_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              rst_req_o,
    output logic              hold_rst_o
);
    logic key_sel, diag_sel, unlocked, force_lock, hold_q, hist_q, req_q;

    assign key_sel  = (bus_addr == ADDR_W'(KEY_OFS));
    assign diag_sel = (bus_addr == ADDR_W'(DIAG_OFS));

    key_tracker #(.N_KEYS(SEQ_LEN), .KW(KEY_W)) u_keys (
        .clk        (clk),
        .rst_n      (rst_n),
        .key_wr     (bus_we && key_sel),
        .key_val    (bus_wdata[KEY_W-1:0]),
        .force_lock (force_lock),
        .unlocked   (unlocked)
    );

    diag_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .diag_wr    (bus_we && diag_sel),
        .wr_hold    (bus_wdata[BIT_HOLD]),
        .wr_arst    (bus_wdata[BIT_ARST]),
        .wr_hist    (bus_wdata[BIT_HIST]),
        .unlocked   (unlocked),
        .force_lock (force_lock),
        .hold_q     (hold_q),
        .hist_q     (hist_q),
        .req_q      (req_q)
    );

    assign rst_req_o  = req_q;
    assign hold_rst_o = hold_q;

    // Read mux: only the diagnostic register returns data.
    always_comb begin
        bus_rdata = '0;
        if (diag_sel) begin
            bus_rdata[BIT_WREN] = unlocked;
            bus_rdata[BIT_HIST] = hist_q;
            bus_rdata[BIT_HOLD] = hold_q;
        end
    end

    p_key_reads_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        key_sel |-> (bus_rdata == '0));
    p_arst_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rdata[BIT_ARST]);
endmodule

// File: tb/sim_diag_unlock_guard.sv
module sim_diag_unlock_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rst_req_o, hold_rst_o;

    always #2 clk = ~clk;

    diag_unlock_guard u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rst_req_o(rst_req_o), .hold_rst_o(hold_rst_o)
    );

    typedef struct {
        int          sel;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    logic  chk = 1'b0;
    int    n_chk = 0;
    int    n_err = 0;
    bit    done = 1'b0;

    localparam logic [7:0] A_KEY  = 8'h04;
    localparam logic [7:0] A_DIAG = 8'h08;

    // Monitor: pops one expected item per checked cycle and compares.
    always @(negedge clk) begin
        if (chk && q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = q.pop_front();
            case (it.sel)
                0:       act = bus_rdata;
                1:       act = {31'b0, rst_req_o};
                default: act = {31'b0, hold_rst_o};
            endcase
            n_chk++;
            if (act !== it.exp) begin
                n_err++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    // Driver tasks start and end one time unit after a rising edge.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic key(input logic [3:0] k);
        wr(A_KEY, {28'hA5C3E91, k});
    endtask

    task automatic expect_val(input int sel, input logic [7:0] a,
                              input logic [31:0] e, input string tag);
        item_t it;
        bus_addr = a;
        it.sel = sel; it.exp = e; it.tag = tag;
        q.push_back(it);
        chk = 1'b1;
        @(posedge clk); #1;
        chk = 1'b0;
    endtask

    task automatic full_unlock();
        key(4'hF); key(4'h4); key(4'hB); key(4'h2); key(4'h7); key(4'hD);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // R1 reset state
        expect_val(0, A_DIAG, 32'h0, "R1 diag after reset");
        expect_val(1, A_DIAG, 32'h0, "R1 rst_req after reset");
        expect_val(2, A_DIAG, 32'h0, "R1 hold after reset");

        // R7 control writes while locked are ignored
        wr(A_DIAG, 32'h0000_0006);
        expect_val(1, A_DIAG, 32'h0, "R7 no request while locked");
        expect_val(2, A_DIAG, 32'h0, "R7 hold unchanged while locked");
        expect_val(0, A_DIAG, 32'h0, "R7 diag unchanged while locked");

        // R2 five keys are not enough, sixth unlocks; R3 upper bits ignored
        key(4'hF); key(4'h4); key(4'hB); key(4'h2); key(4'h7);
        expect_val(0, A_DIAG, 32'h0, "R2 locked after five keys");
        key(4'hD);
        expect_val(0, A_DIAG, 32'h80, "R2 R3 unlocked after six keys");
        key(4'h5);
        expect_val(0, A_DIAG, 32'h80, "R2 stays unlocked on non-flush key");
        expect_val(0, A_KEY, 32'h0, "R11 key register reads zero");

        // R6 flush after unlock
        key(4'h0);
        expect_val(0, A_DIAG, 32'h0, "R6 flush relocks");

        // R4 wrong key mid sequence restarts
        key(4'hF); key(4'h4); key(4'hB); key(4'h5); key(4'h2); key(4'h7); key(4'hD);
        expect_val(0, A_DIAG, 32'h0, "R4 mismatch restarts");

        // R5 mismatch equal to first key leaves step one
        key(4'h0);
        key(4'hF); key(4'h4); key(4'hF); key(4'h4); key(4'hB);
        key(4'h2); key(4'h7); key(4'hD);
        expect_val(0, A_DIAG, 32'h80, "R5 first key on mismatch counts");

        // R6 flush mid sequence
        key(4'h0);
        key(4'hF); key(4'h4); key(4'h0); key(4'hB); key(4'h2); key(4'h7); key(4'hD);
        expect_val(0, A_DIAG, 32'h0, "R6 flush mid sequence");

        // R8 hold-reset writable when unlocked
        full_unlock();
        wr(A_DIAG, 32'h0000_0002);
        expect_val(2, A_DIAG, 32'h1, "R8 hold output set");
        expect_val(0, A_DIAG, 32'h82, "R8 hold reads back");

        // R9 reset request pulse, relock, history
        wr(A_DIAG, 32'h0000_0006);
        expect_val(1, A_DIAG, 32'h1, "R9 request high one cycle after write");
        expect_val(1, A_DIAG, 32'h0, "R9 request drops after one cycle");
        expect_val(0, A_DIAG, 32'h22, "R9 relocked with history set");

        // R7 locked again: hold write ignored
        wr(A_DIAG, 32'h0000_0000);
        expect_val(2, A_DIAG, 32'h1, "R7 hold kept after relock");

        // R10 history write-one-to-clear, write zero keeps it
        wr(A_DIAG, 32'h0000_0000);
        expect_val(0, A_DIAG, 32'h22, "R10 write zero keeps history");
        wr(A_DIAG, 32'h0000_0020);
        expect_val(0, A_DIAG, 32'h02, "R10 write one clears history");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule